// File: doc/BRIEF.md
# Bidirectional Common Scan Shifter

This block is the row-select stage of a liquid-crystal common driver. A one-bit line marker, sampled from a frame-start input, walks along a chain of line stages. It moves one stage on each falling edge of the line clock. A direction input decides whether the marker enters at the first line and climbs, or enters at the last active line and descends. A duty input sets the chain length to either the full 240 lines or the first 120 lines only. In the short setting, lines 121 to 240 stay unselected.

Each line then gets a 2-bit drive-level code. The code depends on whether the line holds the marker, on the alternation phase input, and on the display-enable input. The analog switches that turn the code into a voltage sit outside this block. When the display is disabled, every line is driven to the lowest level, but the marker keeps moving underneath.

Top module: `com_scan_shifter`

## Requirements
- R1: While `rst_n` is low, which takes effect asynchronously, every stage is unselected. With `disp_en`=1 and `alt_m`=0, every line then reads code 10.
- R2: Stages change only on a falling edge of `line_clk`. A rising edge leaves every code unchanged.
- R3: With `shift_left`=1, the falling edge loads `frame_mark` into line 1, and each line k takes the previous value of line k-1.
- R4: With `shift_left`=0 and `duty_full`=1, the falling edge loads `frame_mark` into line 240, and each line k takes the previous value of line k+1.
- R5: With `shift_left`=0 and `duty_full`=0, the falling edge loads `frame_mark` into line 120, and lines 1 to 119 take the previous value of the line above.
- R6: With `duty_full`=0, lines 121 to 240 become unselected on the falling edge and stay that way.
- R7: The chain does not wrap around. A marker leaving the last active line, or line 1 when descending, is dropped.
- R8: A selected line with `disp_en`=1 reads code 00 (V1) when `alt_m`=0 and code 11 (V6) when `alt_m`=1.
- R9: An unselected line with `disp_en`=1 reads code 10 (V5) when `alt_m`=0 and code 01 (V2) when `alt_m`=1.
- R10: With `disp_en`=0, every line reads code 00 (V1). The shifting continues, so after `disp_en` returns to 1 the marker is found where the clock count puts it.
- R11: With `shift_left`=1 and `duty_full`=0, a marker at line 120 is dropped on the next falling edge rather than entering line 121.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| line_clk | input | 1 | Line clock; the stages shift on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_mark | input | 1 | Marker bit loaded into the entry stage |
| alt_m | input | 1 | Alternation phase |
| shift_left | input | 1 | 1: enter at line 1 and climb; 0: enter at the top active line and descend |
| duty_full | input | 1 | 1: 240 active lines; 0: 120 active lines |
| disp_en | input | 1 | 0 forces every line to V1 |
| level_code | output | 480 | Line k code at bits [2k-1:2k-2]; 00 V1, 01 V2, 10 V5, 11 V6 |

## Verification
The hardest situations to reach are the far ends of the chain. The marker must be walked across all 240 stages to show that it drops off line 240 instead of wrapping, and across 120 stages in the short setting to show that it never leaks into line 121. The stimulus gets there by driving one marker pulse and then clocking the exact number of falling edges. The bench also switches direction and duty while markers are still in flight. This leaves stray markers in the upper half and in the middle, and checks that changing the duty clears the upper half and that a reversed marker retraces its path.

// File: rtl/com_scan_pkg.sv
package com_scan_pkg;

    typedef enum logic [1:0] {
        LVL_V1 = 2'b00,
        LVL_V2 = 2'b01,
        LVL_V5 = 2'b10,
        LVL_V6 = 2'b11
    } drive_lvl_e;

    // Level for one line from its select bit, alternation phase and enable.
    function automatic drive_lvl_e pick_level(input logic sel,
                                              input logic m,
                                              input logic en);
        drive_lvl_e lvl;
        if (!en)      lvl = LVL_V1;
        else if (sel) lvl = m ? LVL_V6 : LVL_V1;
        else          lvl = m ? LVL_V2 : LVL_V5;
        return lvl;
    endfunction

endpackage

// File: rtl/com_scan_chain.sv
module com_scan_chain #(
    parameter int NUM_LINES   = 240,
    parameter int SHORT_LINES = 120
) (
    input  logic                 line_clk,
    input  logic                 rst_n,
    input  logic                 frame_mark,
    input  logic                 shift_left,
    input  logic                 duty_full,
    output logic [NUM_LINES-1:0] sel
);

    typedef struct packed {
        logic [NUM_LINES-1:0] sel;
    } chain_t;

    chain_t state_d, state_q;

    logic [NUM_LINES:0] up_src;     // up_src[i] feeds stage i when climbing
    logic [NUM_LINES:0] dn_ext;     // dn_ext[i+1] feeds stage i when descending

    always_comb begin
        up_src = {state_q.sel, frame_mark};
        dn_ext = {1'b0, state_q.sel};
        state_d = state_q;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (!duty_full && (i >= SHORT_LINES)) begin
                state_d.sel[i] = 1'b0;
            end else if (shift_left) begin
                state_d.sel[i] = up_src[i];
            end else if ((duty_full && (i == NUM_LINES - 1)) ||
                         (!duty_full && (i == SHORT_LINES - 1))) begin
                state_d.sel[i] = frame_mark;
            end else begin
                state_d.sel[i] = dn_ext[i+1];
            end
        end
    end

    always_ff @(negedge line_clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign sel = state_q.sel;

    // R3: climbing entry takes the marker at line 1
    p_climb_entry_r3: assert property (@(negedge line_clk) disable iff (!rst_n)
        shift_left |=> (sel[0] == $past(frame_mark)));

    // R4: full descending entry at the last line
    p_full_descend_entry_r4: assert property (@(negedge line_clk) disable iff (!rst_n)
        (!shift_left && duty_full) |=> (sel[NUM_LINES-1] == $past(frame_mark)));

    // R5: short descending entry at the top of the short window
    p_short_descend_entry_r5: assert property (@(negedge line_clk) disable iff (!rst_n)
        (!shift_left && !duty_full) |=> (sel[SHORT_LINES-1] == $past(frame_mark)));

    // R6: upper part idle in short mode
    p_upper_idle_r6: assert property (@(negedge line_clk) disable iff (!rst_n)
        !duty_full |=> (sel[NUM_LINES-1:SHORT_LINES] == '0));

    // R7: no wraparound when climbing past the last line
    p_no_wrap_r7: assert property (@(negedge line_clk) disable iff (!rst_n)
        (shift_left && !frame_mark) |=> !sel[0]);

endmodule

// File: rtl/com_level_enc.sv
module com_level_enc
    import com_scan_pkg::*;
#(
    parameter int NUM_LINES = 240
) (
    input  logic                   alt_m,
    input  logic                   disp_en,
    input  logic [NUM_LINES-1:0]   sel,
    output logic [2*NUM_LINES-1:0] level_code
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        drive_lvl_e lvl;
        assign lvl = pick_level(sel[g], alt_m, disp_en);
        assign level_code[2*g +: 2] = lvl;
    end

endmodule

// File: rtl/com_scan_shifter.sv
module com_scan_shifter #(
    parameter int NUM_LINES   = 240,
    parameter int SHORT_LINES = 120
) (
    input  logic                   line_clk,
    input  logic                   rst_n,
    input  logic                   frame_mark,
    input  logic                   alt_m,
    input  logic                   shift_left,
    input  logic                   duty_full,
    input  logic                   disp_en,
    output logic [2*NUM_LINES-1:0] level_code
);

    logic [NUM_LINES-1:0] sel;

    com_scan_chain #(
        .NUM_LINES  (NUM_LINES),
        .SHORT_LINES(SHORT_LINES)
    ) i_chain (
        .line_clk  (line_clk),
        .rst_n     (rst_n),
        .frame_mark(frame_mark),
        .shift_left(shift_left),
        .duty_full (duty_full),
        .sel       (sel)
    );

    com_level_enc #(
        .NUM_LINES(NUM_LINES)
    ) i_enc (
        .alt_m     (alt_m),
        .disp_en   (disp_en),
        .sel       (sel),
        .level_code(level_code)
    );

    // R10: disabled display drives every line to V1
    p_off_all_v1_r10: assert property (@(negedge line_clk) disable iff (!rst_n)
        !disp_en |-> (level_code == '0));

    // R8 / R9: low code bit follows the alternation phase on line 1
    p_phase_first_r9: assert property (@(negedge line_clk) disable iff (!rst_n)
        disp_en |-> (level_code[0] == alt_m));

    // R8 / R9: a selected and an unselected line never share a code
    p_sel_code_r8: assert property (@(negedge line_clk) disable iff (!rst_n)
        (disp_en && sel[0] && !sel[1]) |-> (level_code[1:0] != level_code[3:2]));

endmodule

// File: tb/test_com_scan_shifter.sv
`timescale 1ns/1ps
module test_com_scan_shifter;

    localparam int N = 240;

    logic           line_clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           frame_mark = 1'b0;
    logic           alt_m = 1'b0;
    logic           shift_left = 1'b1;
    logic           duty_full = 1'b1;
    logic           disp_en = 1'b1;
    logic [2*N-1:0] level_code;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #10 line_clk = ~line_clk;

    com_scan_shifter i_com_scan_shifter (
        .line_clk  (line_clk),
        .rst_n     (rst_n),
        .frame_mark(frame_mark),
        .alt_m     (alt_m),
        .shift_left(shift_left),
        .duty_full (duty_full),
        .disp_en   (disp_en),
        .level_code(level_code)
    );

    typedef struct packed {
        logic       shl;
        logic       duty;
        logic       flm;
        logic       m;
        logic       en;
        logic [7:0] line;
        logic [1:0] code;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'd1,   2'b00},
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'd2,   2'b11},
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'd1,   2'b01},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd4,   2'b00},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd3,   2'b10},
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'd6,   2'b00},
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'd7,   2'b11},
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'd240, 2'b00},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd239, 2'b00},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd4,   2'b00},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd120, 2'b00},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd237, 2'b01},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd118, 2'b00},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'd119, 2'b00},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd120, 2'b00},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd121, 2'b10},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd120, 2'b10}
    };
    localparam string TAG [NV] = '{
        "R3", "R8", "R9", "R3", "R9", "R10", "R10", "R4", "R4",
        "R4", "R5", "R6", "R5", "R11", "R11", "R6", "R11"
    };

    function automatic logic [1:0] code_of(input int line);
        return level_code[2*(line-1) +: 2];
    endfunction

    // Lines showing a selected code (00 or 11), valid while disp_en is 1
    function automatic int count_selected();
        int c = 0;
        for (int k = 1; k <= N; k++)
            if (code_of(k) == 2'b00 || code_of(k) == 2'b11) c++;
        return c;
    endfunction

    task automatic check_line(input string tag, input int line, input logic [1:0] exp);
        logic [1:0] act = code_of(line);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s line %0d: got %b expected %b", tag, line, act, exp);
        end
    endtask

    task automatic check_count(input string tag, input int exp);
        int act = count_selected();
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s selected lines: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic fall();
        @(negedge line_clk);
        #1;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R1: state during reset
        #25;
        check_count("R1", 0);
        check_line("R1", 240, 2'b10);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            shift_left = VEC[v].shl;
            duty_full  = VEC[v].duty;
            frame_mark = VEC[v].flm;
            alt_m      = VEC[v].m;
            disp_en    = VEC[v].en;
            fall();
            check_line(TAG[v], int'(VEC[v].line), VEC[v].code);
        end

        // R1: asynchronous reset in mid cycle clears markers at lines 4 and 5
        frame_mark = 1'b0; alt_m = 1'b0; disp_en = 1'b1;
        #3 rst_n = 1'b0;
        #2;
        check_count("R1", 0);
        check_line("R1", 4, 2'b10);
        rst_n = 1'b1;

        // R2: the rising edge does not shift
        fall();
        shift_left = 1'b1; duty_full = 1'b1; frame_mark = 1'b1;
        @(posedge line_clk);
        #1;
        check_line("R2", 1, 2'b10);
        fall();
        check_line("R2", 1, 2'b00);
        frame_mark = 1'b0;

        // R7: climb to line 240, then drop off without wrapping
        repeat (239) fall();
        check_line("R7", 240, 2'b00);
        fall();
        check_count("R7", 0);
        check_line("R7", 1, 2'b10);

        // R5: short descent from line 120 down to line 1, then drop off
        shift_left = 1'b0; duty_full = 1'b0; frame_mark = 1'b1;
        fall();
        frame_mark = 1'b0;
        check_line("R5", 120, 2'b00);
        repeat (119) fall();
        check_line("R5", 1, 2'b00);
        fall();
        check_count("R7", 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule